// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs single read and write accesses on an external asynchronous memory. A requester raises `req_i` with a direction, an address and write data. The block then drives a chip enable, a read or write strobe, the address and the write data through three timed phases: setup, strobe and hold. The length of each phase is a count of clock cycles. Reads and writes each have their own three length fields. The block captures these lengths, together with the address, the data and the direction, on the cycle it accepts the request, so the requester may change its inputs while the access runs.

A slow device can stretch the strobe phase by holding the ready pin low. The pin may change at any time because it passes through a two-stage synchronizer. The sequencer looks at the synchronized level in the last programmed strobe cycle. That level is the pin level from two cycles earlier. While the level is low the strobe is held. Stretching is allowed only when setup plus strobe is at least four cycles. For shorter accesses the pin is ignored. Read data is captured on the edge that ends the strobe. The requester sees a one-cycle acknowledge in the last hold cycle.

Top module: `async_mem_strobe_ctrl`

## Requirements
- R1: During reset and after it with no request, chip enable, both strobes, write-data drive enable and acknowledge are low, and read data is zero.
- R2: A request seen while idle starts an access on the next edge. Chip enable is then high with no strobe for the number of cycles in the setup field of the chosen direction (read fields when `we_i`=0, write fields when `we_i`=1).
- R3: The strobe phase follows setup. For reads only `mem_re_o` is high, and for writes only `mem_we_o` is high. Unless ready stretches it, the phase lasts the strobe field's count of cycles.
- R4: After the strobe, chip enable stays high with no strobe for the hold field's count of cycles.
- R5: A setup, strobe or hold field of zero gives a one-cycle phase.
- R6: When the effective setup plus strobe is at least 4 and `mem_rdy_i` is low from acceptance until it rises in cycle a+k, with cycle a being the first setup cycle, the strobe lasts max(strobe, k+3-setup) cycles.
- R7: When the effective setup plus strobe is below 4, `mem_rdy_i` has no effect and the strobe lasts exactly its programmed length.
- R8: After a read, `rdata_o` holds the value that `mem_rdata_i` had in the last strobe cycle.
- R9: `ack_o` is high for exactly one cycle, the last hold cycle. The block is idle on the next cycle. Requests made during an access are not accepted.
- R10: Throughout the access, `mem_addr_o` and `mem_wdata_o` keep the values captured at acceptance. `mem_wdata_oe_o` is high for the whole of a write access, and low for reads and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rd_setup_i | input | SETUP_W | Read setup length in cycles |
| rd_strobe_i | input | STROBE_W | Read strobe length in cycles |
| rd_hold_i | input | HOLD_W | Read hold length in cycles |
| wr_setup_i | input | SETUP_W | Write setup length in cycles |
| wr_strobe_i | input | STROBE_W | Write strobe length in cycles |
| wr_hold_i | input | HOLD_W | Write hold length in cycles |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_ce_o | output | 1 | Memory chip enable, active high |
| mem_re_o | output | 1 | Memory read strobe, active high |
| mem_we_o | output | 1 | Memory write strobe, active high |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_wdata_oe_o | output | 1 | Write-data drive enable |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_rdy_i | input | 1 | Asynchronous ready from memory |

## Verification
The first sweep runs every setup, strobe and hold length from zero to three, for both directions, with ready high. It measures each phase at the pins. The unused direction's fields are loaded with different values, so a swap between read and write lengths shows up, and zero fields separate the one-cycle minimum from an absent phase. The second sweep varies setup and strobe from zero to five and raises ready at nine different offsets. This separates a stall that starts too early or too late from a stall on an access too short to allow one. Read data changes every cycle and the request inputs are scrambled during each access. Together these pin down the exact capture edge and show that only the values present at acceptance are used.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/amc_rdy_sync.sv
module amc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[0] <= 1'b0;
        else         q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= 1'b0;
        else         q[i] <= q[i-1];
      end
    end
  end

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int SETUP_W     = 4,
  parameter int STROBE_W    = 6,
  parameter int HOLD_W      = 4,
  parameter int CNT_W       = 6,
  parameter int MIN_STRETCH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [SETUP_W-1:0]  rd_setup_i,
  input  logic [STROBE_W-1:0] rd_strobe_i,
  input  logic [HOLD_W-1:0]   rd_hold_i,
  input  logic [SETUP_W-1:0]  wr_setup_i,
  input  logic [STROBE_W-1:0] wr_strobe_i,
  input  logic [HOLD_W-1:0]   wr_hold_i,
  input  logic                rdy_i,
  output phase_e              phase_o,
  output logic                accept_o,
  output logic                strobe_done_o,
  output logic                hold_done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   STRETCH_MIN = (CNT_W+1)'(MIN_STRETCH);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] s_sel, t_sel, h_sel;
  logic [CNT_W-1:0] s_q, t_q, h_q;
  logic [CNT_W:0]   st_sum;
  logic             str_en_q;
  logic             strobe_last;

  // effective lengths of the direction being requested, zero promoted to one
  always_comb begin
    s_sel = we_i ? CNT_W'(wr_setup_i)  : CNT_W'(rd_setup_i);
    t_sel = we_i ? CNT_W'(wr_strobe_i) : CNT_W'(rd_strobe_i);
    h_sel = we_i ? CNT_W'(wr_hold_i)   : CNT_W'(rd_hold_i);
    if (s_sel == '0) s_sel = ONE;
    if (t_sel == '0) t_sel = ONE;
    if (h_sel == '0) h_sel = ONE;
    st_sum = (CNT_W+1)'(s_sel) + (CNT_W+1)'(t_sel);
  end

  assign accept_o      = (ph_q == PH_IDLE) && req_i;
  assign strobe_last   = (ph_q == PH_STROBE) && (cnt_q >= t_q);
  assign strobe_done_o = strobe_last && (!str_en_q || rdy_i);
  assign hold_done_o   = (ph_q == PH_HOLD) && (cnt_q >= h_q);
  assign phase_o       = ph_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_i) begin
          ph_d  = PH_SETUP;
          cnt_d = ONE;
        end
      end
      PH_SETUP: begin
        if (cnt_q >= s_q) begin
          ph_d  = PH_STROBE;
          cnt_d = ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_STROBE: begin
        if (strobe_done_o) begin
          ph_d  = PH_HOLD;
          cnt_d = ONE;
        end else if (!strobe_last) begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_HOLD: begin
        if (hold_done_o) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      s_q      <= ONE;
      t_q      <= ONE;
      h_q      <= ONE;
      str_en_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept_o) begin
        s_q      <= s_sel;
        t_q      <= t_sel;
        h_q      <= h_sel;
        str_en_q <= (st_sum >= STRETCH_MIN);
      end
    end
  end

  // R2
  setup_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SETUP && cnt_q < s_q) |=> (ph_q == PH_SETUP));

  // R4
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HOLD && cnt_q < h_q) |=> (ph_q == PH_HOLD));

  // R6
  ready_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_last && str_en_q && !rdy_i) |=> (ph_q == PH_STROBE));

  // R7
  no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_last && !str_en_q) |=> (ph_q == PH_HOLD));
endmodule

// File: rtl/amc_bus.sv
module amc_bus #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              strobe_done_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
      end
      if (strobe_done_i && !we_q) rdata_q <= mem_rdata_i;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign rdata_o = rdata_q;

  // R10
  bus_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(we_q)));

  // R8
  rdata_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_done_i && !we_q) |=> (rdata_q == $past(mem_rdata_i)));
endmodule

// File: rtl/async_mem_strobe_ctrl.sv
module async_mem_strobe_ctrl
  import amc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SETUP_W     = 4,
  parameter int STROBE_W    = 6,
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_STRETCH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [SETUP_W-1:0]  rd_setup_i,
  input  logic [STROBE_W-1:0] rd_strobe_i,
  input  logic [HOLD_W-1:0]   rd_hold_i,
  input  logic [SETUP_W-1:0]  wr_setup_i,
  input  logic [STROBE_W-1:0] wr_strobe_i,
  input  logic [HOLD_W-1:0]   wr_hold_i,
  output logic                ack_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                mem_ce_o,
  output logic                mem_re_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_wdata_oe_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_rdy_i
);
  localparam int MAX_SH = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int CNT_W  = (STROBE_W > MAX_SH) ? STROBE_W : MAX_SH;

  phase_e phase;
  logic   accept, strobe_done, hold_done, rdy_sync, we_q, busy;

  amc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (mem_rdy_i),
    .sync_o  (rdy_sync)
  );

  amc_seq #(
    .SETUP_W     (SETUP_W),
    .STROBE_W    (STROBE_W),
    .HOLD_W      (HOLD_W),
    .CNT_W       (CNT_W),
    .MIN_STRETCH (MIN_STRETCH)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .we_i          (we_i),
    .rd_setup_i    (rd_setup_i),
    .rd_strobe_i   (rd_strobe_i),
    .rd_hold_i     (rd_hold_i),
    .wr_setup_i    (wr_setup_i),
    .wr_strobe_i   (wr_strobe_i),
    .wr_hold_i     (wr_hold_i),
    .rdy_i         (rdy_sync),
    .phase_o       (phase),
    .accept_o      (accept),
    .strobe_done_o (strobe_done),
    .hold_done_o   (hold_done)
  );

  assign busy = (phase != PH_IDLE);

  amc_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept),
    .busy_i        (busy),
    .strobe_done_i (strobe_done),
    .we_i          (we_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .mem_rdata_i   (mem_rdata_i),
    .addr_o        (mem_addr_o),
    .wdata_o       (mem_wdata_o),
    .we_o          (we_q),
    .rdata_o       (rdata_o)
  );

  assign mem_ce_o       = busy;
  assign mem_re_o       = (phase == PH_STROBE) && !we_q;
  assign mem_we_o       = (phase == PH_STROBE) && we_q;
  assign mem_wdata_oe_o = busy && we_q;
  assign ack_o          = hold_done;

  // R9
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (!ack_o && !mem_ce_o));
endmodule

// File: tb/sim_async_mem_strobe_ctrl.sv
module sim_async_mem_strobe_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, mem_rdy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [3:0]    rd_setup = '0, wr_setup = '0, rd_hold = '0, wr_hold = '0;
  logic [5:0]    rd_strobe = '0, wr_strobe = '0;
  logic          ack, mem_ce, mem_re, mem_we, mem_oe;
  logic [DW-1:0] rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_rdata = DW'(cyc * 37 + 11);

  async_mem_strobe_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rd_setup_i(rd_setup), .rd_strobe_i(rd_strobe), .rd_hold_i(rd_hold),
    .wr_setup_i(wr_setup), .wr_strobe_i(wr_strobe), .wr_hold_i(wr_hold),
    .ack_o(ack), .rdata_o(rdata), .mem_ce_o(mem_ce), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_wdata_oe_o(mem_oe),
    .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run(input bit wr, input int s, input int t, input int h, input int rr);
    int a, su_n, st_n, ho_n, ack_n, bus_bad, last_rd, se, te, he, exp_st;
    bit seen_st;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    su_n = 0; st_n = 0; ho_n = 0; ack_n = 0; bus_bad = 0; last_rd = -1; seen_st = 1'b0;
    if (wr) begin
      wr_setup = 4'(s); wr_strobe = 6'(t); wr_hold = 4'(h);
      rd_setup = 4'(s + 2); rd_strobe = 6'(t + 3); rd_hold = 4'(h + 1);
    end else begin
      rd_setup = 4'(s); rd_strobe = 6'(t); rd_hold = 4'(h);
      wr_setup = 4'(s + 2); wr_strobe = 6'(t + 3); wr_hold = 4'(h + 1);
    end
    @(negedge clk);
    ea = AW'($urandom); ed = DW'($urandom);
    req = 1'b1; we = wr; addr = ea; wdata = ed; mem_rdy = 1'b0;
    a = cyc + 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      mem_rdy = ((cyc - a) >= rr);
      addr = AW'($urandom); wdata = DW'($urandom); we = 1'($urandom);
      if (mem_ce) begin
        if (mem_re || mem_we) begin
          st_n++; seen_st = 1'b1;
          if (wr ? (mem_re || !mem_we) : (mem_we || !mem_re)) bus_bad++;
          if (mem_re) last_rd = int'(mem_rdata);
        end else if (seen_st) ho_n++;
        else su_n++;
        if (mem_addr !== ea) bus_bad++;
        if (wr && (!mem_oe || mem_wdata !== ed)) bus_bad++;
        if (!wr && mem_oe) bus_bad++;
      end else bus_bad++;
      if (ack) begin
        ack_n++;
        req = 1'b0;
        break;
      end
    end
    req = 1'b0;
    @(negedge clk);
    chk(!mem_ce && !mem_oe && !ack && !mem_re && !mem_we, "R9 idle after one-cycle ack",
        int'({mem_ce, mem_oe, ack, mem_re, mem_we}), 0);
    mem_rdy = 1'b0;
    se = eff(s); te = eff(t); he = eff(h);
    exp_st = te;
    if (se + te >= 4 && rr + 3 - se > te) exp_st = rr + 3 - se;
    chk(su_n == se, (s == 0) ? "R5 zero setup" : "R2 setup length", su_n, se);
    if (rr == 0) chk(st_n == exp_st, (t == 0) ? "R5 zero strobe" : "R3 strobe length", st_n, exp_st);
    else if (se + te >= 4) chk(st_n == exp_st, "R6 ready stall", st_n, exp_st);
    else chk(st_n == exp_st, "R7 ready ignored", st_n, exp_st);
    chk(ho_n == he, (h == 0) ? "R5 zero hold" : "R4 hold length", ho_n, he);
    chk(ack_n == 1, "R9 ack seen", ack_n, 1);
    chk(bus_bad == 0, "R10 bus/strobe stability", bus_bad, 0);
    if (!wr) chk(int'(rdata) == last_rd, "R8 read capture", int'(rdata), last_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R9 access never completed actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_ce && !mem_re && !mem_we && !mem_oe && !ack, "R1 in reset",
        int'({mem_ce, mem_re, mem_we, mem_oe, ack}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_ce && !mem_re && !mem_we && !mem_oe && !ack, "R1 idle after reset",
        int'({mem_ce, mem_re, mem_we, mem_oe, ack}), 0);
    chk(rdata == '0, "R1 rdata after reset", int'(rdata), 0);

    // timing grid, ready always high
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int h = 0; h < 4; h++)
            run(1'(w), s, t, h, 0);

    // ready rise offsets against short and long accesses
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 6; s++)
        for (int t = 0; t < 6; t++)
          for (int rr = 0; rr < 9; rr++)
            run(1'(w), s, t, 1, rr);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule